// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against a stalled program, and can instead serve as a periodic tick source. Software writes one 16-bit control word. The upper byte of every write must carry an unlock key. The lower byte selects the following:

- whether the counter is frozen,
- whether expiry resets the system or only raises a flag,
- which of two count sources is used,
- how many counts make up one period.

Software can also zero the running counter through a self-clearing bit. In watchdog use, this is how the program proves it is still alive.

The counter advances on one of two clock-enable inputs: a fast one and a slow one. When the selected period elapses, the block sets an expiry flag. In watchdog use it also raises a one-cycle system reset request. A write with a wrong key raises the same reset request.

The reset request returns the control word and the counter to their power-up state. It leaves the flag and the interrupt enable untouched, so that after restart software can tell that the timer caused the reset. In interval use, the flag gated by the enable bit forms an interrupt request, and acknowledging that interrupt clears the flag.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst`, `ctl_rdata` reads 16'h6900 (watchdog mode, fast source, longest period, running) and `flag_q`, `ie_q`, `irq` and `rst_req` are 0.
- R2: A write with `ctl_wdata[15:8]` = 8'h5A loads hold (bit 7), interval mode (bit 4), slow-source select (bit 2) and period select (bits 1:0). A read always returns 8'h69 in bits 15:8 and 0 in bits 6, 5 and 3.
- R3: A write whose upper byte is not 8'h5A leaves the control word unchanged and drives `rst_req` high for exactly the one cycle that follows the write.
- R4: The period select picks the expiry length measured from a zero counter: 00 gives 32768 counts, 01 gives 8192, 10 gives 512 and 11 gives 64. The flag is set on the edge that applies the last of those counts.
- R5: On expiry the flag is set in both modes. With bit 4 = 0 (watchdog mode), `rst_req` is also high in the cycle after expiry. With bit 4 = 1 (interval mode), `rst_req` stays 0.
- R6: A keyed write with bit 3 = 1 zeroes the counter on that edge, so a full period is needed again before the next expiry.
- R7: While hold (bit 7) is 1, the counter does not advance and no expiry occurs.
- R8: With bit 2 = 0, only `tick_fast` advances the counter. With bit 2 = 1, only `tick_slow` advances it.
- R9: In the cycle after `rst_req` is high, the control word reads 16'h6900 and the counter restarts from zero. `flag_q` and `ie_q` keep their values.
- R10: `flag_clr` clears the flag in either mode. `irq_ack` clears it only in interval mode. If an expiry and a clear fall on the same edge, the expiry wins.
- R11: `irq` equals `flag_q` AND `ie_q` AND interval mode. `ie_q` is loaded from `ie_wdata` when `ie_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Fast count-source enable |
| tick_slow | input | 1 | Slow count-source enable |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data (key in upper byte) |
| ctl_rdata | output | 16 | Control word read value |
| ie_wr | input | 1 | Interrupt enable write strobe |
| ie_wdata | input | 1 | Interrupt enable write value |
| ie_q | output | 1 | Interrupt enable bit |
| flag_clr | input | 1 | Software clear of the expiry flag |
| irq_ack | input | 1 | Interrupt acknowledge |
| flag_q | output | 1 | Expiry flag |
| irq | output | 1 | Interval interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The counter is internal, so any fault in it shows up only as an early or late flag. The bench therefore counts the selected-source ticks between a clearing write and the flag edge, for each period and for both sources. A miscounted tap or a wrong source changes that figure by at least a factor of two, and this shows up within one period.

A key-decode fault appears one cycle after the offending write, either as a missing `rst_req` pulse or as a changed read value. A fault in the reset path appears in the cycle after that, as a control word other than 16'h6900. Flag-retention faults are visible at once on `flag_q` after a reset request or an acknowledge.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int CNT_W = 16;
    localparam logic [7:0] WR_KEY = 8'h5A;
    localparam logic [7:0] RD_KEY = 8'h69;

    typedef enum logic [1:0] {
        PER_32K = 2'b00,
        PER_8K  = 2'b01,
        PER_512 = 2'b10,
        PER_64  = 2'b11
    } period_e;

    typedef struct packed {
        logic    hold;
        logic    interval_mode;
        logic    slow_src;
        period_e period;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{hold: 1'b0, interval_mode: 1'b0,
                                   slow_src: 1'b0, period: PER_32K};

    // Highest counter bit whose falling edge marks expiry.
    function automatic int tap_bit(period_e p);
        case (p)
            PER_32K: return 14;
            PER_8K:  return 12;
            PER_512: return 8;
            default: return 5;
        endcase
    endfunction

    function automatic logic [15:0] pack_ctl(cfg_t c);
        return {RD_KEY, c.hold, 2'b00, c.interval_mode, 1'b0,
                c.slow_src, c.period};
    endfunction

endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sys_rst_req,
    input  logic        wr,
    input  logic [15:0] wdata,
    output cfg_t        cfg,
    output logic        clr_pulse,
    output logic        bad_key,
    output logic [15:0] rdata
);

    logic key_ok;
    logic accept;
    logic unused_wbits;

    assign key_ok       = (wdata[15:8] == WR_KEY);
    assign accept       = wr && key_ok && !sys_rst_req;
    assign clr_pulse    = accept && wdata[3];
    assign bad_key      = wr && !key_ok && !sys_rst_req;
    assign unused_wbits = ^wdata[6:5];

    always_ff @(posedge clk) begin
        if (rst || sys_rst_req) begin
            cfg <= CFG_RESET;
        end else if (accept) begin
            cfg.hold          <= wdata[7];
            cfg.interval_mode <= wdata[4];
            cfg.slow_src      <= wdata[2];
            cfg.period        <= period_e'(wdata[1:0]);
        end
    end

    assign rdata = pack_ctl(cfg);

    // R3
    bad_key_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> $stable(cfg) || $past(sys_rst_req));

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sync_clr,
    input  logic    hold,
    input  logic    slow_src,
    input  period_e period,
    input  logic    tick_fast,
    input  logic    tick_slow,
    output logic    expire
);

    logic [W-1:0] cnt;
    logic [W-1:0] mask;
    logic         tick;
    logic         advance;

    always_comb begin
        mask = '0;
        for (int i = 0; i < W; i++) begin
            if (i <= tap_bit(period)) mask[i] = 1'b1;
        end
    end

    assign tick    = slow_src ? tick_slow : tick_fast;
    assign advance = tick && !hold && !sync_clr;
    assign expire  = advance && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || sync_clr) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !sync_clr) |=> $stable(cnt));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sync_clr |=> (cnt == '0));

endmodule

// File: rtl/kwd_flag.sv
module kwd_flag (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic interval_mode,
    input  logic flag_clr,
    input  logic irq_ack,
    input  logic ie_wr,
    input  logic ie_wdata,
    output logic flag_q,
    output logic ie_q,
    output logic irq
);

    logic clear_now;

    assign clear_now = flag_clr || (irq_ack && interval_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (clear_now) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
        end else if (ie_wr) begin
            ie_q <= ie_wdata;
        end
    end

    assign irq = flag_q && ie_q && interval_mode;

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr && !(irq_ack && interval_mode)) |=> flag_q);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_fast,
    input  logic        tick_slow,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    output logic [15:0] ctl_rdata,
    input  logic        ie_wr,
    input  logic        ie_wdata,
    output logic        ie_q,
    input  logic        flag_clr,
    input  logic        irq_ack,
    output logic        flag_q,
    output logic        irq,
    output logic        rst_req
);

    cfg_t cfg;
    logic clr_pulse;
    logic bad_key;
    logic expire;

    kwd_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sys_rst_req (rst_req),
        .wr          (ctl_wr),
        .wdata       (ctl_wdata),
        .cfg         (cfg),
        .clr_pulse   (clr_pulse),
        .bad_key     (bad_key),
        .rdata       (ctl_rdata)
    );

    kwd_counter #(.W(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .sync_clr  (rst_req || clr_pulse),
        .hold      (cfg.hold),
        .slow_src  (cfg.slow_src),
        .period    (cfg.period),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .expire    (expire)
    );

    kwd_flag u_flag (
        .clk           (clk),
        .rst           (rst),
        .expire        (expire),
        .interval_mode (cfg.interval_mode),
        .flag_clr      (flag_clr),
        .irq_ack       (irq_ack),
        .ie_wr         (ie_wr),
        .ie_wdata      (ie_wdata),
        .flag_q        (flag_q),
        .ie_q          (ie_q),
        .irq           (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= bad_key || (expire && !cfg.interval_mode);
        end
    end

    // R3
    bad_key_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[15:8] != 8'h5A && !rst_req) |=> rst_req);

    // R3
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R9
    rst_clears_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (ctl_rdata == 16'h6900));

    // R5
    interval_no_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg.interval_mode && !bad_key) |=> !rst_req);

endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_fast = 1'b0, tick_slow = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        ie_wr = 1'b0, ie_wdata = 1'b0, ie_q;
    logic        flag_clr = 1'b0, irq_ack = 1'b0;
    logic        flag_q, irq, rst_req;

    int checks = 0;
    int errors = 0;
    int phase  = 0;
    logic last_fast, last_slow;

    always #10 clk = ~clk;

    keyed_watchdog u0 (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata), .ie_q(ie_q),
        .flag_clr(flag_clr), .irq_ack(irq_ack), .flag_q(flag_q),
        .irq(irq), .rst_req(rst_req)
    );

    // Vector: [19:18] period select, [17] interval mode, [16] slow source,
    // [15:0] expected ticks until the flag rises.
    localparam int NV = 6;
    localparam logic [19:0] VEC [NV] = '{
        {2'b11, 1'b1, 1'b0, 16'd64},
        {2'b10, 1'b1, 1'b0, 16'd512},
        {2'b01, 1'b1, 1'b0, 16'd8192},
        {2'b00, 1'b1, 1'b0, 16'd32768},
        {2'b11, 1'b1, 1'b1, 16'd64},
        {2'b10, 1'b0, 1'b0, 16'd512}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle; slow enable fires every fourth cycle when ticks are on.
    task automatic step(bit ticks_on = 1'b1);
        @(negedge clk);
        tick_fast = ticks_on;
        tick_slow = ticks_on && (phase == 3);
        last_fast = tick_fast;
        last_slow = tick_slow;
        if (ticks_on) phase = (phase + 1) % 4;
        @(posedge clk);
        #1;
        ctl_wr = 1'b0; flag_clr = 1'b0; irq_ack = 1'b0; ie_wr = 1'b0;
    endtask

    task automatic wr_ctl(logic [15:0] d, bit fclr = 1'b0);
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0;
        ctl_wr = 1'b1; ctl_wdata = d; flag_clr = fclr;
        @(posedge clk);
        #1;
        ctl_wr = 1'b0; flag_clr = 1'b0;
    endtask

    function automatic logic [15:0] cfgw(bit hold, bit imode, bit clr,
                                         bit slow, logic [1:0] per);
        return {8'h5A, hold, 2'b00, imode, clr, slow, per};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 ctl", ctl_rdata, 16'h6900);
        check("R1 flag", flag_q, 0);
        check("R1 ie", ie_q, 0);
        check("R1 irq", irq, 0);
        check("R1 rst_req", rst_req, 0);

        // R4 R5 R8: table walk
        for (int v = 0; v < NV; v++) begin
            logic [19:0] e;
            int n;
            e = VEC[v];
            wr_ctl(cfgw(0, e[17], 1, e[16], e[19:18]), 1'b1);
            n = 0;
            while (flag_q == 1'b0 && n < 40000) begin
                step();
                if (e[16] ? last_slow : last_fast) n++;
            end
            check("R4 R8 period ticks", n, e[15:0]);
            check("R5 rst_req on expiry", rst_req, !e[17]);
            step();
            if (!e[17]) begin
                check("R9 ctl after expiry reset", ctl_rdata, 16'h6900);
                check("R9 flag kept", flag_q, 1);
            end
        end

        // R2 keyed write and readback
        wr_ctl(cfgw(0, 1, 1, 0, 2'b11), 1'b1);
        check("R2 readback", ctl_rdata, 16'h6913);
        wr_ctl(16'h5AE4);
        check("R2 bits 6,5 read zero", ctl_rdata, 16'h6984);

        // R7 hold freezes counter
        wr_ctl(cfgw(1, 1, 1, 0, 2'b11), 1'b1);
        repeat (200) step();
        check("R7 hold no expiry", flag_q, 0);
        wr_ctl(cfgw(0, 1, 0, 0, 2'b11));
        repeat (63) step();
        check("R7 count kept at zero, 63", flag_q, 0);
        step();
        check("R7 expiry at 64 after release", flag_q, 1);

        // R6 clear mid-period
        wr_ctl(cfgw(0, 1, 1, 0, 2'b11), 1'b1);
        repeat (40) step();
        wr_ctl(cfgw(0, 1, 1, 0, 2'b11));
        repeat (63) step();
        check("R6 no expiry at 63 after clear", flag_q, 0);
        step();
        check("R6 expiry at 64 after clear", flag_q, 1);

        // R11 interrupt gating
        check("R11 irq off with ie=0", irq, 0);
        @(negedge clk); ie_wr = 1'b1; ie_wdata = 1'b1;
        @(posedge clk); #1 ie_wr = 1'b0;
        check("R11 irq on", irq, 1);
        // R10 acknowledge in interval mode clears flag
        @(negedge clk); irq_ack = 1'b1; tick_fast = 1'b0;
        @(posedge clk); #1 irq_ack = 1'b0;
        check("R10 ack clears in interval", flag_q, 0);
        check("R11 irq drops", irq, 0);

        // R3 R9 bad key: flag and ie kept
        wr_ctl(cfgw(0, 1, 1, 0, 2'b11), 1'b1);
        repeat (64) step(); // flag set
        wr_ctl(16'h1234);
        check("R3 rst_req after bad key", rst_req, 1);
        check("R3 ctl unchanged", ctl_rdata, 16'h6913);
        step(0);
        check("R3 single pulse", rst_req, 0);
        check("R9 ctl reset", ctl_rdata, 16'h6900);
        check("R9 flag kept", flag_q, 1);
        check("R9 ie kept", ie_q, 1);
        check("R11 no irq in watchdog mode", irq, 0);

        // R10 ack ignored in watchdog mode, flag_clr works
        @(negedge clk); irq_ack = 1'b1; tick_fast = 1'b0;
        @(posedge clk); #1 irq_ack = 1'b0;
        check("R10 ack ignored in watchdog", flag_q, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
        check("R10 software clear", flag_q, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule